// File: doc/BRIEF.md
# Virtual-PC Iterative Indirect Target Predictor

This block predicts where an indirect branch will jump without holding any target storage of its own. It recasts one indirect branch as a chain of virtual conditional branches. Each link in the chain is a fresh lookup address and history value, offered one per cycle to a direction predictor and a branch target buffer that already exist next to it in the front end. The first virtual branch whose buffer entry hits and whose direction comes back taken supplies the predicted target.

A request carries the branch PC and the current global history. It is taken through a valid/ready handshake while the block is idle. On every working cycle the block drives a lookup address and history, and it samples the hit, target and taken answers in the same cycle. The search ends in one of two ways. A win produces a one-cycle prediction pulse with the target and the number of the iteration that produced it, so later stages can train the right virtual branch. A buffer miss, or running out of iterations, produces a one-cycle stall pulse. A flush input aborts any search at once.

The address for the next iteration is formed and registered while the current lookup is in flight. The external lookup path therefore only ever sees a flop output.

Top module: `vpc_iter_predictor`

## Requirements
- R1: `req_ready` is high exactly when the block is idle and `flush` is low; a request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_valid` has no effect at any other time.
- R2: In the cycle after a request is taken, `lk_valid` is high, `lk_addr` equals the request PC and `lk_hist` equals the request history (iteration 1).
- R3: For iteration k of 2 or more, `lk_addr` equals the request PC XOR S(k), where S(k) = (k * 0x9E3779B9 mod 2^32) XOR 0x5A5A0000; the values S(1)..S(MAX_ITER) are all distinct.
- R4: From one iteration to the next, `lk_hist` is shifted left by one bit with a zero entering bit 0, so iteration k presents the request history shifted left by k-1.
- R5: If in a lookup cycle `btb_hit` and `dir_taken` are both high, then in the following cycle `pred_valid` is high, `pred_target` equals the `btb_target` of that cycle, `pred_iter` equals that iteration number k, and the block is idle.
- R6: If in a lookup cycle `btb_hit` is low, then in the following cycle `stall_out` is high and the block is idle.
- R7: If iteration MAX_ITER gets a hit but is not taken, the following cycle shows `stall_out`; a request never makes more than MAX_ITER lookups, and `pred_iter` always lies between 1 and MAX_ITER when `pred_valid` is high.
- R8: Lookups of one request occupy consecutive cycles, one per cycle, with `lk_valid` high throughout and `req_ready` low throughout.
- R9: A cycle with `flush` high leaves the block idle in the next cycle, with `lk_valid`, `pred_valid` and `stall_out` low; a flush in the same cycle as a terminating lookup suppresses that result's pulse.
- R10: Each request that is not flushed produces exactly one pulse, either `pred_valid` or `stall_out` and never both, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Abort the current search and return to idle |
| req_valid | input | 1 | A prediction request is offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_pc | input | ADDR_W | PC of the indirect branch |
| req_ghr | input | HIST_W | Global history at fetch of the branch |
| lk_valid | output | 1 | Lookup address and history are valid this cycle |
| lk_addr | output | ADDR_W | Virtual PC presented to the external predictors |
| lk_hist | output | HIST_W | Virtual history presented to the direction predictor |
| btb_hit | input | 1 | Target buffer holds an entry for `lk_addr` |
| btb_target | input | ADDR_W | Target read from the buffer |
| dir_taken | input | 1 | Direction predictor answer for this virtual branch |
| pred_valid | output | 1 | One-cycle pulse: a target was predicted |
| pred_target | output | ADDR_W | Predicted next fetch address |
| pred_iter | output | ITER_W | Iteration number that produced the target |
| stall_out | output | 1 | One-cycle pulse: no target found, front end must wait |

## Verification
Two events can land in the same cycle: a flush and the lookup that would end the search. The bench provokes this by raising `flush` exactly in the lookup cycle where the modelled buffer answers with a winning hit, and again where it answers with a miss. In both cases it expects no pulse in the next cycle and an idle block ready for a new request. A second overlap arises when a request is offered together with a flush while the block is idle. There the bench expects `req_ready` to be low and no lookup in the following cycle.

// File: rtl/vpc_pkg.sv
// Package: shared types and the salt generator for the virtual-PC predictor.
// Assumes salts are consumed at 32 bits or truncated by the user.
package vpc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vpc_state_t;

    // Pseudo-random salt for iteration k: an odd-multiplier scramble keeps
    // every k below 2^32 distinct, the fixed XOR keeps S(k) away from zero.
    function automatic logic [31:0] salt_of(input int unsigned k);
        logic [31:0] prod;
        prod = 32'(k) * 32'h9E3779B9;
        return prod ^ 32'h5A5A0000;
    endfunction

endpackage

// File: rtl/vpc_salt_rom.sv
// Module: constant table of per-iteration salts, one entry per iteration.
// Assumes idx is 1-based; an out-of-range index reads as zero.
module vpc_salt_rom #(
    parameter int ADDR_W   = 32,
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic [ITER_W:0]   idx,
    output logic [ADDR_W-1:0] salt
);
    import vpc_pkg::*;

    logic [ADDR_W-1:0] table_q [MAX_ITER];

    // Build the hard-wired entries, one per iteration number.
    for (genvar g = 0; g < MAX_ITER; g++) begin : g_entry
        assign table_q[g] = ADDR_W'(salt_of(g + 1));
    end

    // Select the entry for the requested iteration.
    always_comb begin
        salt = '0;
        for (int i = 0; i < MAX_ITER; i++) begin
            if (int'(idx) == i + 1) salt = table_q[i];
        end
    end

endmodule

// File: rtl/vpc_iter_ctrl.sv
// Module: idle/run sequencer and iteration counter.
// Decides each cycle whether the search wins, gives up, or advances.
// Assumes btb_hit/dir_taken answer the lookup of the same cycle.
module vpc_iter_ctrl #(
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              btb_hit,
    input  logic              dir_taken,
    output logic              req_ready,
    output logic              running,
    output logic              start,
    output logic              advance,
    output logic              hit_take,
    output logic              give_up,
    output logic [ITER_W-1:0] iter
);
    import vpc_pkg::*;

    vpc_state_t state_q;
    logic       at_last;

    // Decode the handshake and the outcome of the current lookup.
    always_comb begin
        running   = (state_q == ST_RUN);
        req_ready = !running && !flush;
        start     = req_valid && req_ready;
        at_last   = (iter == ITER_W'(MAX_ITER));
        hit_take  = running && btb_hit && dir_taken;
        give_up   = running && !hit_take && (!btb_hit || at_last);
        advance   = running && !hit_take && !give_up;
    end

    // Sequence state and iteration number; flush has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q <= ST_IDLE;
            iter    <= '0;
        end else if (start) begin
            state_q <= ST_RUN;
            iter    <= ITER_W'(1);
        end else if (hit_take || give_up) begin
            state_q <= ST_IDLE;
        end else if (advance) begin
            iter <= iter + ITER_W'(1);
        end
    end

endmodule

// File: rtl/vpc_vstate.sv
// Module: virtual PC and virtual history registers.
// The next lookup address is formed from the saved PC and the next salt
// during the current lookup, so the lookup port is driven from flops only.
module vpc_vstate #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [HIST_W-1:0] req_ghr,
    input  logic [ADDR_W-1:0] next_salt,
    output logic [ADDR_W-1:0] vaddr,
    output logic [HIST_W-1:0] vhist
);
    logic [ADDR_W-1:0] base_pc;

    // Load on request, step on each not-taken iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pc <= '0;
            vaddr   <= '0;
            vhist   <= '0;
        end else if (start) begin
            base_pc <= req_pc;
            vaddr   <= req_pc;
            vhist   <= req_ghr;
        end else if (advance) begin
            vaddr <= base_pc ^ next_salt;
            vhist <= {vhist[HIST_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/vpc_iter_predictor.sv
// Module: top of the virtual-PC iterative indirect target predictor.
// Drives one lookup per cycle into external direction and target predictors
// and reports either a target with its iteration number or a stall.
// Assumes the external predictors answer combinationally within the cycle.
module vpc_iter_predictor #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [HIST_W-1:0] req_ghr,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_addr,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              btb_hit,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic              dir_taken,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ITER_W-1:0] pred_iter,
    output logic              stall_out
);
    logic              running, start, advance, hit_take, give_up;
    logic [ITER_W-1:0] iter;
    logic [ADDR_W-1:0] next_salt;
    logic [ITER_W:0]   next_idx;

    vpc_iter_ctrl #(.MAX_ITER(MAX_ITER), .ITER_W(ITER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .btb_hit(btb_hit), .dir_taken(dir_taken), .req_ready(req_ready),
        .running(running), .start(start), .advance(advance),
        .hit_take(hit_take), .give_up(give_up), .iter(iter)
    );

    // Salt for the iteration that follows the current one.
    assign next_idx = {1'b0, iter} + (ITER_W + 1)'(1);

    vpc_salt_rom #(.ADDR_W(ADDR_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)) u_rom (
        .idx(next_idx), .salt(next_salt)
    );

    vpc_vstate #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_vst (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .req_pc(req_pc), .req_ghr(req_ghr), .next_salt(next_salt),
        .vaddr(lk_addr), .vhist(lk_hist)
    );

    assign lk_valid = running;

    // Register the outcome as a one-cycle pulse; flush cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            stall_out   <= 1'b0;
            pred_target <= '0;
            pred_iter   <= '0;
        end else begin
            pred_valid <= hit_take && !flush;
            stall_out  <= give_up && !flush;
            if (hit_take) begin
                pred_target <= btb_target;
                pred_iter   <= iter;
            end
        end
    end

endmodule

// File: rtl/vpc_checker.sv
// Module: protocol checker for the virtual-PC predictor, bound to the top.
module vpc_checker #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              req_ready,
    input logic              lk_valid,
    input logic [HIST_W-1:0] lk_hist,
    input logic              btb_hit,
    input logic [ADDR_W-1:0] btb_target,
    input logic              dir_taken,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] pred_target,
    input logic [ITER_W-1:0] pred_iter,
    input logic              stall_out
);
    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!lk_valid && !flush));

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(lk_valid) && !$past(flush) && $past(rst_n))
        |-> lk_hist == {$past(lk_hist[HIST_W-2:0]), 1'b0});

    // R5
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !flush && btb_hit && dir_taken)
        |=> (pred_valid && pred_target == $past(btb_target)));

    // R6
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !flush && !btb_hit) |=> stall_out);

    // R7
    iter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (pred_iter >= ITER_W'(1) && pred_iter <= ITER_W'(MAX_ITER)));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_valid && !pred_valid && !stall_out));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_valid && stall_out));

    // R10
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid || stall_out) |=> (!pred_valid && !stall_out));

endmodule

bind vpc_iter_predictor vpc_checker #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
    .lk_valid(lk_valid), .lk_hist(lk_hist), .btb_hit(btb_hit),
    .btb_target(btb_target), .dir_taken(dir_taken), .pred_valid(pred_valid),
    .pred_target(pred_target), .pred_iter(pred_iter), .stall_out(stall_out)
);

// File: tb/sim_vpc_iter_predictor.sv
module sim_vpc_iter_predictor;
    localparam int AW = 32;
    localparam int HW = 16;
    localparam int MI = 12;
    localparam int IW = $clog2(MI + 1);
    localparam logic [31:0] TKEY = 32'h0F0F_1234;
    localparam int M_TAKE = 0, M_MISS = 1, M_NONE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_pc = '0;
    logic [HW-1:0] req_ghr = '0;
    logic          lk_valid;
    logic [AW-1:0] lk_addr;
    logic [HW-1:0] lk_hist;
    logic          btb_hit, dir_taken;
    logic [AW-1:0] btb_target;
    logic          pred_valid, stall_out;
    logic [AW-1:0] pred_target;
    logic [IW-1:0] pred_iter;

    int vectors = 0;
    int errors  = 0;
    int sc_mode = M_NONE;
    int sc_w    = 1;
    logic [31:0] sc_pc = '0;

    always #4 clk = ~clk;

    vpc_iter_predictor #(.ADDR_W(AW), .HIST_W(HW), .MAX_ITER(MI)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_ready(req_ready), .req_pc(req_pc), .req_ghr(req_ghr),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hist(lk_hist),
        .btb_hit(btb_hit), .btb_target(btb_target), .dir_taken(dir_taken),
        .pred_valid(pred_valid), .pred_target(pred_target),
        .pred_iter(pred_iter), .stall_out(stall_out)
    );

    // Expected virtual PC for iteration k, written from the requirement text.
    function automatic logic [31:0] want_addr(input logic [31:0] pc, input int k);
        longint unsigned s;
        if (k == 1) return pc;
        s = (longint'(k) * 64'h9E3779B9) & 64'hFFFF_FFFF;
        return pc ^ (32'(s) ^ 32'h5A5A0000);
    endfunction

    // Behavioural external predictors keyed on the presented address.
    always_comb begin
        logic [31:0] win;
        win        = want_addr(sc_pc, sc_w);
        btb_hit    = lk_valid && !(sc_mode == M_MISS && lk_addr == win);
        dir_taken  = lk_valid && (sc_mode == M_TAKE && lk_addr == win);
        btb_target = lk_addr ^ TKEY;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_quiet(input string tag);
        check({tag, " lk_valid"}, 64'(lk_valid), 0);
        check({tag, " pred_valid"}, 64'(pred_valid), 0);
        check({tag, " stall_out"}, 64'(stall_out), 0);
    endtask

    // One request, compared every cycle; fl selects an iteration to flush in (0 = none).
    task automatic run_req(input logic [31:0] pc, input logic [15:0] ghr,
                           input int mode, input int w, input int fl);
        sc_mode = mode; sc_w = w; sc_pc = pc;
        check("R1 ready when idle", 64'(req_ready), 1);
        req_valid = 1'b1; req_pc = pc; req_ghr = ghr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= MI; k++) begin
            logic [31:0] ea;
            logic        t_take, t_stall;
            ea = want_addr(pc, k);
            check("R8 lookup active", 64'(lk_valid), 1);
            check("R8 ready low", 64'(req_ready), 0);
            check(k == 1 ? "R2 first address" : "R3 salted address", 64'(lk_addr), 64'(ea));
            check(k == 1 ? "R2 first history" : "R4 shifted history",
                  64'(lk_hist), 64'(16'(ghr << (k - 1))));
            check("R10 no early pulse", 64'({pred_valid, stall_out}), 0);
            t_take  = (mode == M_TAKE && k == w);
            t_stall = (mode == M_MISS && k == w) || k == MI;
            if (fl == k) begin
                flush = 1'b1;
                #1 check("R9 ready low in flush", 64'(req_ready), 0);
                @(negedge clk);
                flush = 1'b0;
                check_quiet("R9 after flush");
                #1 check("R9 idle after flush", 64'(req_ready), 1);
                return;
            end
            @(negedge clk);
            if (t_take) begin
                check("R5 pred pulse", 64'(pred_valid), 1);
                check("R5 target", 64'(pred_target), 64'(ea ^ TKEY));
                check("R5 iteration", 64'(pred_iter), 64'(k));
                check("R10 no stall with pred", 64'(stall_out), 0);
                check("R5 idle", 64'(lk_valid), 0);
                return;
            end
            if (t_stall) begin
                check(k == w && mode == M_MISS ? "R6 miss stall" : "R7 limit stall",
                      64'(stall_out), 1);
                check("R10 no pred with stall", 64'(pred_valid), 0);
                check("R7 lookups stop", 64'(lk_valid), 0);
                return;
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R10 reset state");
        check("R1 ready after reset", 64'(req_ready), 1);

        run_req(32'h0040_1000, 16'hA5C3, M_TAKE, 1, 0);
        run_req(32'h0040_2468, 16'h8001, M_TAKE, 3, 0);
        run_req(32'h1234_5678, 16'hFFFF, M_MISS, 1, 0);
        run_req(32'h0BAD_F00C, 16'h1357, M_MISS, 4, 0);
        run_req(32'h7000_0040, 16'h0F0F, M_NONE, 1, 0);
        run_req(32'h0000_0004, 16'hC001, M_TAKE, MI, 0);
        // Pulse cycles above: single-cycle check one cycle later.
        @(negedge clk);
        check_quiet("R10 pulse lasts one cycle");

        // Flush mid-search, and flush colliding with a terminating lookup.
        run_req(32'h0055_0000, 16'h00F0, M_TAKE, 5, 2);
        run_req(32'h0066_0010, 16'h3C3C, M_TAKE, 2, 2);
        run_req(32'h0077_0020, 16'h5A5A, M_MISS, 1, 1);
        run_req(32'h0088_0030, 16'h0001, M_NONE, 1, MI);

        // Request offered together with flush while idle must be ignored.
        sc_mode = M_NONE; sc_w = 1; sc_pc = 32'hDEAD_0000;
        req_valid = 1'b1; req_pc = 32'hDEAD_0000; flush = 1'b1;
        #1 check("R1 ready low under flush", 64'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        check_quiet("R1 no lookup after ignored request");

        // Idle cycles without requests stay quiet.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_quiet("R8 idle quiet");
        end

        // Back-to-back requests with a sweep of winning iterations.
        for (int i = 1; i <= MI; i++) begin
            run_req(32'h0100_0000 + 32'(i * 64), 16'(i * 16'h1111), M_TAKE, i, 0);
        end
        for (int i = 2; i <= 6; i++) begin
            run_req(32'h0200_0000 + 32'(i * 8), 16'(i * 16'h0707), M_MISS, i, 0);
        end

        @(negedge clk);
        check_quiet("R10 final idle");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule